// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides an input clock by an integer held in a bit field of a 32-bit control register. A simple write port updates the register, and the whole register can always be read back. The field's position (`SHIFT`, `FIELD_W`) and the way it is turned into a divisor (`MODE`) are fixed at elaboration. There are four decodings: field plus one, raw field with a zero policy, two to the power of the field, and a search through a key/divisor table. A status output reports the divisor currently in force, and a sticky flag reports that the register has held a value with no valid divisor.

The divided clock goes high first in each period. It stays high for floor(N/2) input cycles and low for the rest. A divisor of one sends the input clock straight to the output. A newly programmed divisor is only adopted when the running period ends, so the output never shows a shortened pulse. When the half-word mask option is set, the field lives in the low 16 bits and each write carries its own bit mask in the upper 16 bits. This lets several agents share one register without a read-modify-write.

Top module: `cdiv_top`

## Requirements
- R1: With `MODE` = field plus one, the divisor in force becomes the field value plus one (field 3 gives 4, field 4 gives 5).
- R2: With `MODE` = raw, a non-zero field value is the divisor itself (field 6 gives 6, field 2 gives 2).
- R3: With `MODE` = raw and `ALLOW_ZERO` = 0, a zero field is invalid.
- R4: With `MODE` = raw and `ALLOW_ZERO` = 1, a zero field selects a divisor of one, and `clk_o` follows `clk_i` with no error raised.
- R5: With `MODE` = power of two, the divisor is 2 raised to the field value (field 3 gives 8, field 5 gives 32, field 0 gives 1).
- R6: With `MODE` = table, entries are searched from index 0 upward. The first entry whose key equals the field supplies the divisor. The first entry with divisor 0 ends the search, so its key and every later entry never match, and a field with no match is invalid. With the default table, keys 0..3 give 2, 3, 5 and 8, key 4 is the terminator, and key 5 (divisor 7) lies beyond it.
- R7: An invalid field leaves the previous divisor in force on `div_o` and `clk_o`. It also sets `err_o`, which then stays at 1 until reset.
- R8: Without the mask option, a write stores all 32 bits and `rd_data_o` returns them. Only bits `SHIFT+FIELD_W-1:SHIFT` affect the divisor (with defaults, bits 7:4).
- R9: With the mask option, a write changes low bit i only when write bit 16+i is 1. Bits 31:16 always read as zero, and a write with an all-zero mask changes nothing.
- R10: A new divisor is adopted only at the end of the running output period. The period in progress at the time of a write completes with the old high and low lengths.
- R11: For a divisor N of 2 or more, each period of `clk_o` is high for floor(N/2) cycles of `clk_i` and then low for N-floor(N/2) cycles. For N = 1, `clk_o` equals `clk_i`.
- R12: During reset, `rd_data_o` equals `RST_VAL`, `div_o` is 1 and `err_o` is 0. The programmed divisor is loaded at the first `clk_i` rising edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided; also clocks the register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 32 | Write data (upper half is the bit mask in mask mode) |
| rd_data_o | output | 32 | Current control register contents |
| clk_o | output | 1 | Divided clock |
| div_o | output | DIV_W | Divisor currently in force |
| err_o | output | 1 | Sticky flag: an invalid field was seen |

## Verification
The bench reprograms the divisor in the middle of a high phase and checks that the running period still completes with its old lengths. A design that adopted the divisor at once would produce a runt high pulse there. Odd divisors are measured for their floor(N/2) high time, which an off-by-one comparator would miss. Zero fields are tried with and without the bypass policy, and table fields are tried at and beyond the terminator. A faulty design would jump to a bogus divisor, fail to hold the old one, or drop the sticky flag on the next valid write. Masked writes with partial and empty masks expose a register that ignores the mask or stores the mask bits.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

   localparam int unsigned CTRL_W = 32;
   localparam int unsigned HALF_W = CTRL_W / 2;

   typedef enum logic [1:0] {
      DEC_PLUS1 = 2'd0,
      DEC_RAW   = 2'd1,
      DEC_POW2  = 2'd2,
      DEC_TABLE = 2'd3
   } dec_mode_e;

endpackage

// File: rtl/cdiv_ctrl_reg.sv
module cdiv_ctrl_reg
   import cdiv_pkg::*;
#(
   parameter int unsigned    SHIFT   = 4,
   parameter int unsigned    FIELD_W = 4,
   parameter logic [CTRL_W-1:0] RST_VAL = 32'h0000_0030,
   parameter bit             HIWORD  = 1'b0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic [CTRL_W-1:0]  wr_data_i,
   output logic [CTRL_W-1:0]  rd_data_o,
   output logic [FIELD_W-1:0] field_o
);

   logic [CTRL_W-1:0] ctrl;

   generate
      if (HIWORD) begin : g_masked
         logic [HALF_W-1:0] low_q;
         logic [HALF_W-1:0] msk;
         assign msk = wr_data_i[CTRL_W-1:HALF_W];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               low_q <= RST_VAL[HALF_W-1:0];
            end else if (wr_en_i) begin
               low_q <= (low_q & ~msk) | (wr_data_i[HALF_W-1:0] & msk);
            end
         end
         assign ctrl = {{HALF_W{1'b0}}, low_q};
      end else begin : g_plain
         logic [CTRL_W-1:0] full_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               full_q <= RST_VAL;
            end else if (wr_en_i) begin
               full_q <= wr_data_i;
            end
         end
         assign ctrl = full_q;
      end
   endgenerate

   assign rd_data_o = ctrl;
   assign field_o   = ctrl[SHIFT +: FIELD_W];

endmodule

// File: rtl/cdiv_decode.sv
module cdiv_decode
   import cdiv_pkg::*;
#(
   parameter dec_mode_e   MODE       = DEC_PLUS1,
   parameter int unsigned FIELD_W    = 4,
   parameter int unsigned DIV_W      = 16,
   parameter bit          ALLOW_ZERO = 1'b0,
   parameter int unsigned TBL_N      = 6,
   parameter logic [TBL_N*FIELD_W-1:0] TBL_KEY = 24'h54_3210,
   parameter logic [TBL_N*DIV_W-1:0]   TBL_DIV = {16'd7, 16'd0, 16'd8, 16'd5, 16'd3, 16'd2}
) (
   input  logic [FIELD_W-1:0] field_i,
   output logic [DIV_W-1:0]   div_o,
   output logic               ok_o
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   // ordered table search, stopping at the first zero divisor
   logic [DIV_W-1:0] tbl_div;
   logic             tbl_hit;

   always_comb begin
      logic             stop;
      logic [DIV_W-1:0] ent;
      stop    = 1'b0;
      tbl_hit = 1'b0;
      tbl_div = '0;
      for (int i = 0; i < int'(TBL_N); i++) begin
         ent = TBL_DIV[i*DIV_W +: DIV_W];
         if (!stop) begin
            if (ent == '0) begin
               stop = 1'b1;
            end else if (!tbl_hit && (TBL_KEY[i*FIELD_W +: FIELD_W] == field_i)) begin
               tbl_hit = 1'b1;
               tbl_div = ent;
            end
         end
      end
   end

   generate
      if (MODE == DEC_PLUS1) begin : g_plus1
         assign div_o = DIV_W'(field_i) + ONE;
         assign ok_o  = 1'b1;
      end else if (MODE == DEC_RAW) begin : g_raw
         logic zero_f;
         assign zero_f = (field_i == '0);
         assign div_o  = zero_f ? ONE : DIV_W'(field_i);
         assign ok_o   = !zero_f || ALLOW_ZERO;
      end else if (MODE == DEC_POW2) begin : g_pow2
         assign div_o = ONE << field_i;
         assign ok_o  = 1'b1;
      end else begin : g_table
         assign div_o = tbl_hit ? tbl_div : ONE;
         assign ok_o  = tbl_hit;
      end
   endgenerate

endmodule

// File: rtl/cdiv_gen.sv
module cdiv_gen #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] nd_i,
   input  logic             ok_i,
   output logic             clk_o,
   output logic             lvl_o,
   output logic [DIV_W-1:0] div_o,
   output logic             err_o
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cur_q, cnt_q;
   logic [DIV_W-1:0] nxt_div, nxt_cnt;
   logic             lvl_q, err_q, at_end, nxt_lvl;

   always_comb begin
      at_end  = (cnt_q == cur_q - ONE);
      nxt_div = (at_end && ok_i) ? nd_i : cur_q;
      nxt_cnt = at_end ? '0 : cnt_q + ONE;
      nxt_lvl = (nxt_cnt < (nxt_div >> 1));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q <= ONE;
         cnt_q <= '0;
         lvl_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         cur_q <= nxt_div;
         cnt_q <= nxt_cnt;
         lvl_q <= nxt_lvl;
         err_q <= err_q | ~ok_i;
      end
   end

   assign clk_o = (cur_q == ONE) ? clk_i : lvl_q;
   assign lvl_o = lvl_q;
   assign div_o = cur_q;
   assign err_o = err_q;

endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
   import cdiv_pkg::*;
#(
   parameter dec_mode_e   MODE       = DEC_PLUS1,
   parameter int unsigned SHIFT      = 4,
   parameter int unsigned FIELD_W    = 4,
   parameter int unsigned DIV_W      = 16,
   parameter bit          ALLOW_ZERO = 1'b0,
   parameter bit          HIWORD     = 1'b0,
   parameter logic [31:0] RST_VAL    = 32'h0000_0030,
   parameter int unsigned TBL_N      = 6,
   parameter logic [TBL_N*FIELD_W-1:0] TBL_KEY = 24'h54_3210,
   parameter logic [TBL_N*DIV_W-1:0]   TBL_DIV = {16'd7, 16'd0, 16'd8, 16'd5, 16'd3, 16'd2}
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [31:0]      wr_data_i,
   output logic [31:0]      rd_data_o,
   output logic             clk_o,
   output logic [DIV_W-1:0] div_o,
   output logic             err_o
);

   localparam int unsigned FIELD_END = SHIFT + FIELD_W;
   localparam int unsigned POW2_NEED = 1 << FIELD_W;

   generate
      if (FIELD_END > CTRL_W) begin : g_chk_fit
         $error("divisor field runs past the control register");
      end
      if (HIWORD && (FIELD_END > HALF_W)) begin : g_chk_half
         $error("mask mode needs the field inside the low half");
      end
      if (HIWORD && (RST_VAL[31:16] != 16'h0)) begin : g_chk_rst
         $error("mask mode needs a zero upper half in the reset value");
      end
      if ((MODE == DEC_POW2) && (DIV_W < POW2_NEED)) begin : g_chk_pow
         $error("DIV_W too small for the power-of-two range");
      end
      if ((MODE != DEC_POW2) && (DIV_W < FIELD_W + 1)) begin : g_chk_div
         $error("DIV_W too small for the field");
      end
      if (ALLOW_ZERO && (MODE != DEC_RAW)) begin : g_chk_zero
         $error("zero bypass applies only to the raw decode");
      end
      if (TBL_N < 1) begin : g_chk_tbl
         $error("table needs at least one entry");
      end
   endgenerate

   logic [FIELD_W-1:0] field;
   logic [DIV_W-1:0]   nd;
   logic               nd_ok;
   logic               lvl_q;

   cdiv_ctrl_reg #(
      .SHIFT   (SHIFT),
      .FIELD_W (FIELD_W),
      .RST_VAL (RST_VAL),
      .HIWORD  (HIWORD)
   ) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rd_data_o (rd_data_o),
      .field_o   (field)
   );

   cdiv_decode #(
      .MODE       (MODE),
      .FIELD_W    (FIELD_W),
      .DIV_W      (DIV_W),
      .ALLOW_ZERO (ALLOW_ZERO),
      .TBL_N      (TBL_N),
      .TBL_KEY    (TBL_KEY),
      .TBL_DIV    (TBL_DIV)
   ) u_dec (
      .field_i (field),
      .div_o   (nd),
      .ok_o    (nd_ok)
   );

   cdiv_gen #(
      .DIV_W (DIV_W)
   ) u_gen (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .nd_i   (nd),
      .ok_i   (nd_ok),
      .clk_o  (clk_o),
      .lvl_o  (lvl_q),
      .div_o  (div_o),
      .err_o  (err_o)
   );

endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [DIV_W-1:0] div_o,
   input logic             err_o,
   input logic             lvl_i
);

   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   // independent count of input cycles within the current output period
   logic [DIV_W-1:0] pc;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pc <= '0;
      end else if (pc >= div_o - ONE) begin
         pc <= '0;
      end else begin
         pc <= pc + ONE;
      end
   end

   p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);

   p_div_nonzero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      div_o != '0);

   p_switch_at_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(div_o) |-> ($past(pc) == $past(div_o) - ONE));

   p_high_time_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_o > ONE) |-> (lvl_i == (pc < (div_o >> 1))));

   p_bypass_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (div_o == ONE) |-> !lvl_i);

endmodule

bind cdiv_top cdiv_chk #(.DIV_W(DIV_W)) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .div_o  (div_o),
   .err_o  (err_o),
   .lvl_i  (lvl_q)
);

// File: tb/tb_cdiv_top.sv
module tb_cdiv_top;
   import cdiv_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] wd = '0;
   logic [5:0]  we = '0;
   logic [5:0]  clko, er;
   logic [15:0] dv [6];
   logic [31:0] rd [6];
   logic [2:0]  sel = '0;
   logic        so;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;
   always_comb so = clko[sel];

   cdiv_top #(.MODE(DEC_PLUS1), .RST_VAL(32'h0000_0030)) dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[0]), .wr_data_i(wd),
      .rd_data_o(rd[0]), .clk_o(clko[0]), .div_o(dv[0]), .err_o(er[0]));
   cdiv_top #(.MODE(DEC_RAW), .ALLOW_ZERO(1'b0), .RST_VAL(32'h0000_0030)) dut_raw (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[1]), .wr_data_i(wd),
      .rd_data_o(rd[1]), .clk_o(clko[1]), .div_o(dv[1]), .err_o(er[1]));
   cdiv_top #(.MODE(DEC_RAW), .ALLOW_ZERO(1'b1), .RST_VAL(32'h0000_0030)) dut_rawz (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[2]), .wr_data_i(wd),
      .rd_data_o(rd[2]), .clk_o(clko[2]), .div_o(dv[2]), .err_o(er[2]));
   cdiv_top #(.MODE(DEC_POW2), .RST_VAL(32'h0000_0010)) dut_pow (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[3]), .wr_data_i(wd),
      .rd_data_o(rd[3]), .clk_o(clko[3]), .div_o(dv[3]), .err_o(er[3]));
   cdiv_top #(.MODE(DEC_TABLE), .RST_VAL(32'h0000_0000)) dut_tbl (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[4]), .wr_data_i(wd),
      .rd_data_o(rd[4]), .clk_o(clko[4]), .div_o(dv[4]), .err_o(er[4]));
   cdiv_top #(.MODE(DEC_PLUS1), .SHIFT(0), .HIWORD(1'b1), .RST_VAL(32'h0000_0003)) dut_hw (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we[5]), .wr_data_i(wd),
      .rd_data_o(rd[5]), .clk_o(clko[5]), .div_o(dv[5]), .err_o(er[5]));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                  req, what, act, act, exp, exp);
      end
   endtask

   task automatic wr(input int idx, input logic [31:0] data);
      @(negedge clk);
      wd      = data;
      we[idx] = 1'b1;
      @(negedge clk);
      we      = '0;
   endtask

   // wait for the first high sample of a divided period
   task automatic settle();
      logic prev;
      prev = so;
      forever begin
         @(negedge clk);
         if (!prev && so) break;
         prev = so;
      end
   endtask

   task automatic meas(output int h, output int l);
      h = 0;
      l = 0;
      while (so) begin h++; @(negedge clk); end
      while (!so) begin l++; @(negedge clk); end
   endtask

   task automatic check_div(input int idx, input int n, input string req);
      int h, l;
      sel = 3'(idx);
      settle();
      meas(h, l);
      meas(h, l);
      chk(req, "high time", 32'(h), 32'(n / 2));
      chk(req, "low time", 32'(l), 32'(n - n / 2));
      chk(req, "divisor status", 32'(dv[idx]), 32'(n));
   endtask

   task automatic check_byp(input int idx, input string req);
      sel = 3'(idx);
      repeat (40) @(negedge clk);
      chk(req, "divisor status one", 32'(dv[idx]), 32'd1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         chk(req, "output low with input", 32'(so), 32'd0);
         @(posedge clk);
         #2;
         chk(req, "output high with input", 32'(so), 32'd1);
      end
   endtask

   task automatic t_reset();
      chk("R12", "reset readback", rd[0], 32'h30);
      chk("R12", "reset divisor", 32'(dv[0]), 32'd1);
      chk("R12", "reset error", 32'(er[0]), 32'd0);
      chk("R12", "reset readback mask mode", rd[5], 32'h3);
      @(negedge clk);
      rst_n = 1'b1;
      check_div(0, 4, "R12");
   endtask

   task automatic t_plus1();
      wr(0, 32'h0000_0040);
      check_div(0, 5, "R1");
      wr(0, 32'hFFFF_FF2F);
      chk("R8", "full readback", rd[0], 32'hFFFF_FF2F);
      check_div(0, 3, "R8");
      wr(0, 32'h0000_0000);
      check_byp(0, "R11");
      chk("R1", "no error", 32'(er[0]), 32'd0);
   endtask

   task automatic t_no_runt();
      int h, l;
      wr(0, 32'h0000_0070);
      check_div(0, 8, "R10");
      wr(0, 32'h0000_0020);
      h = 2;
      while (so) begin h++; @(negedge clk); end
      l = 0;
      while (!so) begin l++; @(negedge clk); end
      chk("R10", "old high completes", 32'(h), 32'd4);
      chk("R10", "old low completes", 32'(l), 32'd4);
      meas(h, l);
      chk("R10", "new high", 32'(h), 32'd1);
      chk("R10", "new low", 32'(l), 32'd2);
   endtask

   task automatic t_raw();
      wr(1, 32'h0000_0060);
      check_div(1, 6, "R2");
      chk("R3", "no error before zero", 32'(er[1]), 32'd0);
      wr(1, 32'h0000_0000);
      @(negedge clk);
      chk("R3", "zero flagged", 32'(er[1]), 32'd1);
      check_div(1, 6, "R7");
      wr(1, 32'h0000_0020);
      check_div(1, 2, "R2");
      chk("R7", "error stays set", 32'(er[1]), 32'd1);
   endtask

   task automatic t_rawz();
      wr(2, 32'h0000_0000);
      check_byp(2, "R4");
      chk("R4", "no error on bypass", 32'(er[2]), 32'd0);
      wr(2, 32'h0000_0050);
      check_div(2, 5, "R4");
   endtask

   task automatic t_pow();
      check_div(3, 2, "R5");
      wr(3, 32'h0000_0030);
      check_div(3, 8, "R5");
      wr(3, 32'h0000_0050);
      check_div(3, 32, "R5");
      wr(3, 32'h0000_0000);
      check_byp(3, "R5");
   endtask

   task automatic t_table();
      check_div(4, 2, "R6");
      wr(4, 32'h0000_0020);
      check_div(4, 5, "R6");
      wr(4, 32'h0000_0030);
      check_div(4, 8, "R6");
      chk("R6", "no error on hit", 32'(er[4]), 32'd0);
      wr(4, 32'h0000_0050);
      @(negedge clk);
      chk("R6", "entry past terminator invalid", 32'(er[4]), 32'd1);
      check_div(4, 8, "R7");
      wr(4, 32'h0000_0040);
      check_div(4, 8, "R6");
   endtask

   task automatic t_mask();
      wr(5, 32'h000F_0005);
      chk("R9", "full mask write", rd[5], 32'h5);
      check_div(5, 6, "R9");
      wr(5, 32'h0000_000A);
      chk("R9", "empty mask ignored", rd[5], 32'h5);
      check_div(5, 6, "R9");
      wr(5, 32'h0003_000E);
      chk("R9", "partial mask", rd[5], 32'h6);
      check_div(5, 7, "R9");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_plus1();
      t_no_runt();
      t_raw();
      t_rawz();
      t_pow();
      t_table();
      t_mask();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule